// File: doc/BRIEF.md
# Coprocessor Register Transfer Unit

This block moves 32-bit and 64-bit values between a host integer core and the register file of a floating-point coprocessor. It holds the coprocessor's data register bank and its small set of system registers. The bank can be seen in two ways. As singles, it is 32 registers of 32 bits. As doubles, the same storage is 16 registers of 64 bits.

The host issues one command per cycle. A command carries an opcode, a register index and up to two host words. Each accepted command produces exactly one response on the following cycle, in command order. A response returns zero, one or two data words. A write also gets a response with zero words, so the host can tell when the write has taken effect. This is how a write to the read-only ID register can be used to serialize a command stream. No command can produce an error.

Top module: `fpx_xfer_unit`

## Requirements
- R1: Opcode codes are:
  - writes: 0 single, 1 double low half, 2 double high half, 3 system, 4 full double, 5 single pair;
  - reads: 8 single, 9 double low half, 10 double high half, 11 system, 12 full double, 13 single pair;
  - codes 6, 7, 14 and 15 change nothing.

  A command is taken on a rising edge while `cmd_valid_i` and `cmd_ready_o` are both high. `rsp_valid_o` is high for exactly one cycle, one cycle later. `rsp_words_o` is 0 for writes and unused codes, 1 for the 32-bit reads and 2 for the 64-bit reads. Response words not counted in `rsp_words_o` are zero.
- R2: Single register 2n is bits [31:0] of double register n, and single register 2n+1 is bits [63:32]. A single write (code 0) is visible through the double half reads. A single read (code 8) sees data written through the double writes.
- R3: A low-half write (code 1) replaces only bits [31:0] of the selected double. A high-half write (code 2) replaces only bits [63:32]. In both cases the other half keeps its value.
- R4: A full double write (code 4) puts `cmd_wd0_i` in bits [31:0] and `cmd_wd1_i` in bits [63:32]. A full double read (code 12) returns bits [31:0] on `rsp_wd0_o` and bits [63:32] on `rsp_wd1_o`.
- R5: A pair write (code 5) at index m writes `cmd_wd0_i` to single m and `cmd_wd1_i` to single m+1. A pair read (code 13) returns single m first and single m+1 second. For m = 31, the index m+1 wraps to 0.
- R6: System select values come from `cmd_idx_i[2:0]`:
  - 0 is the ID register;
  - 1 is the control/status register;
  - 2 is the exception register;
  - 3 and 4 are the two instruction-capture registers.

  Selects 1 to 4 read back the value last written to them.
- R7: A read of select 0 returns the parameter `ID_VALUE`. A write to select 0 gets a normal zero-word response and leaves every register unchanged.
- R8: System selects 5, 6 and 7 read as zero, and writes to them change no register.
- R9: While `rst_ni` is low, `cmd_ready_o` and `rsp_valid_o` are low. After reset, `cmd_ready_o` is high and stays high. Every bank register and every writable system register reads zero after reset.
- R10: The double commands (codes 1, 2, 4, 9, 10, 12) take the double index from `cmd_idx_i[3:0]` and ignore `cmd_idx_i[4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Unit can take a command |
| cmd_op_i | input | 4 | Opcode |
| cmd_idx_i | input | 5 | Single index, double index in [3:0], or system select in [2:0] |
| cmd_wd0_i | input | 32 | First host word |
| cmd_wd1_i | input | 32 | Second host word |
| rsp_valid_o | output | 1 | Response present |
| rsp_words_o | output | 2 | Number of data words in the response |
| rsp_wd0_o | output | 32 | First returned word |
| rsp_wd1_o | output | 32 | Second returned word |

## Verification
The bench writes through one view of the bank and reads back through the other. Single writes are read back as double halves, and double and pair writes are read back as singles. This exposes any error in the alias mapping or in the word order.

Half writes are followed by reads of the other half, which separates a correct half write from a write to the whole double.

Pair commands at odd indices, at even indices and at index 31 check the carry into the next double and the wrap to index 0.

A long random stream mixes every opcode, including the unused codes, the ID register and the unmapped system selects. It is compared against a behavioural model of the register file every cycle.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int OP_W  = 4;
  localparam int SEL_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_WR_SGL  = 4'd0,
    OP_WR_DLO  = 4'd1,
    OP_WR_DHI  = 4'd2,
    OP_WR_SYS  = 4'd3,
    OP_WR_DBL  = 4'd4,
    OP_WR_PAIR = 4'd5,
    OP_RD_SGL  = 4'd8,
    OP_RD_DLO  = 4'd9,
    OP_RD_DHI  = 4'd10,
    OP_RD_SYS  = 4'd11,
    OP_RD_DBL  = 4'd12,
    OP_RD_PAIR = 4'd13
  } fpx_op_e;

  typedef enum logic [SEL_W-1:0] {
    SYS_ID   = 3'd0,
    SYS_CTL  = 3'd1,
    SYS_EXC  = 3'd2,
    SYS_CAP0 = 3'd3,
    SYS_CAP1 = 3'd4
  } fpx_sys_e;
endpackage

// File: rtl/fpx_xfer_decode.sv
module fpx_xfer_decode
  import fpx_pkg::*;
#(
  parameter int NUM_SGL = 32,
  localparam int IDX_W = $clog2(NUM_SGL)
) (
  input  logic             acc_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [1:0]       we_o,
  output logic [IDX_W-1:0] wi0_o,
  output logic [IDX_W-1:0] wi1_o,
  output logic [IDX_W-1:0] ri0_o,
  output logic [IDX_W-1:0] ri1_o,
  output logic             sys_we_o,
  output logic             sys_rd_o,
  output logic [1:0]       words_o
);
  fpx_op_e          op;
  logic [IDX_W-1:0] dbl_lo, dbl_hi, nxt;
  logic [1:0]       we_raw;
  logic             sys_we_raw;

  assign op     = fpx_op_e'(op_i);
  // double index ignores the top index bit
  assign dbl_lo = {idx_i[IDX_W-2:0], 1'b0};
  assign dbl_hi = {idx_i[IDX_W-2:0], 1'b1};
  assign nxt    = idx_i + 1'b1;  // wraps at NUM_SGL (power of two)

  always_comb begin
    we_raw     = 2'b00;
    sys_we_raw = 1'b0;
    sys_rd_o   = 1'b0;
    words_o    = 2'd0;
    wi0_o      = idx_i;
    wi1_o      = nxt;
    ri0_o      = idx_i;
    ri1_o      = nxt;
    case (op)
      OP_WR_SGL:  we_raw = 2'b01;
      OP_WR_DLO:  begin we_raw = 2'b01; wi0_o = dbl_lo; end
      OP_WR_DHI:  begin we_raw = 2'b01; wi0_o = dbl_hi; end
      OP_WR_DBL:  begin we_raw = 2'b11; wi0_o = dbl_lo; wi1_o = dbl_hi; end
      OP_WR_PAIR: we_raw = 2'b11;
      OP_WR_SYS:  sys_we_raw = 1'b1;
      OP_RD_SGL:  words_o = 2'd1;
      OP_RD_DLO:  begin words_o = 2'd1; ri0_o = dbl_lo; end
      OP_RD_DHI:  begin words_o = 2'd1; ri0_o = dbl_hi; end
      OP_RD_DBL:  begin words_o = 2'd2; ri0_o = dbl_lo; ri1_o = dbl_hi; end
      OP_RD_PAIR: words_o = 2'd2;
      OP_RD_SYS:  begin words_o = 2'd1; sys_rd_o = 1'b1; end
      default:    ;
    endcase
  end

  assign we_o     = acc_i ? we_raw : 2'b00;
  assign sys_we_o = acc_i & sys_we_raw;
endmodule

// File: rtl/fpx_sgl_bank.sv
module fpx_sgl_bank #(
  parameter int NUM_SGL = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W = $clog2(NUM_SGL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        we_i,
  input  logic [IDX_W-1:0]  wi0_i,
  input  logic [IDX_W-1:0]  wi1_i,
  input  logic [DATA_W-1:0] wd0_i,
  input  logic [DATA_W-1:0] wd1_i,
  input  logic [IDX_W-1:0]  ri0_i,
  input  logic [IDX_W-1:0]  ri1_i,
  output logic [DATA_W-1:0] rd0_o,
  output logic [DATA_W-1:0] rd1_o
);
  logic [NUM_SGL-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SGL; i++) begin
        if (we_i[1] && wi1_i == IDX_W'(i))      mem_q[i] <= wd1_i;
        else if (we_i[0] && wi0_i == IDX_W'(i)) mem_q[i] <= wd0_i;
      end
    end
  end

  assign rd0_o = mem_q[ri0_i];
  assign rd1_o = mem_q[ri1_i];

  assert_wr_ports_distinct_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i[0] && we_i[1]) |-> (wi0_i != wi1_i));

  assert_wr_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i[0] |=> mem_q[$past(wi0_i)] == $past(wd0_i));

  assert_partner_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i[0] && !we_i[1]) |=>
      mem_q[{$past(wi0_i[IDX_W-1:1]), ~$past(wi0_i[0])}]
        == $past(mem_q[{wi0_i[IDX_W-1:1], ~wi0_i[0]}]));
endmodule

// File: rtl/fpx_sys_regs.sv
module fpx_sys_regs
  import fpx_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h4110_2A05,
  localparam int NUM_RW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_RW-1:0][DATA_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_RW; i++) begin
        if (sel_i == SEL_W'(i + 1)) regs_q[i] <= wd_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SYS_ID:   rdata_o = DATA_W'(ID_VALUE);
      SYS_CTL:  rdata_o = regs_q[0];
      SYS_EXC:  rdata_o = regs_q[1];
      SYS_CAP0: rdata_o = regs_q[2];
      SYS_CAP1: rdata_o = regs_q[3];
      default:  rdata_o = '0;
    endcase
  end

  assert_id_write_inert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SYS_ID) |=> $stable(regs_q));

  assert_unmapped_write_inert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i > SEL_W'(NUM_RW)) |=> $stable(regs_q));
endmodule

// File: rtl/fpx_xfer_unit.sv
module fpx_xfer_unit
  import fpx_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          NUM_SGL  = 32,
  parameter logic [31:0] ID_VALUE = 32'h4110_2A05,
  localparam int IDX_W = $clog2(NUM_SGL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [DATA_W-1:0] cmd_wd0_i,
  input  logic [DATA_W-1:0] cmd_wd1_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_words_o,
  output logic [DATA_W-1:0] rsp_wd0_o,
  output logic [DATA_W-1:0] rsp_wd1_o
);
  logic              ready_q, acc;
  logic [1:0]        we, words;
  logic [IDX_W-1:0]  wi0, wi1, ri0, ri1;
  logic              sys_we, sys_rd;
  logic [DATA_W-1:0] bank_rd0, bank_rd1, sys_rdata;
  logic              rsp_valid_q;
  logic [1:0]        rsp_words_q;
  logic [DATA_W-1:0] rsp_wd0_q, rsp_wd1_q;

  assign acc = cmd_valid_i & ready_q;

  fpx_xfer_decode #(.NUM_SGL(NUM_SGL)) u_dec (
    .acc_i   (acc),
    .op_i    (cmd_op_i),
    .idx_i   (cmd_idx_i),
    .we_o    (we),
    .wi0_o   (wi0),
    .wi1_o   (wi1),
    .ri0_o   (ri0),
    .ri1_o   (ri1),
    .sys_we_o(sys_we),
    .sys_rd_o(sys_rd),
    .words_o (words)
  );

  fpx_sgl_bank #(.NUM_SGL(NUM_SGL), .DATA_W(DATA_W)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (we),
    .wi0_i (wi0),
    .wi1_i (wi1),
    .wd0_i (cmd_wd0_i),
    .wd1_i (cmd_wd1_i),
    .ri0_i (ri0),
    .ri1_i (ri1),
    .rd0_o (bank_rd0),
    .rd1_o (bank_rd1)
  );

  fpx_sys_regs #(.DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_sys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sys_we),
    .sel_i  (cmd_idx_i[SEL_W-1:0]),
    .wd_i   (cmd_wd0_i),
    .rdata_o(sys_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_words_q <= 2'd0;
      rsp_wd0_q   <= '0;
      rsp_wd1_q   <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= acc;
      if (acc) begin
        rsp_words_q <= words;
        rsp_wd0_q   <= (words == 2'd0) ? '0 : (sys_rd ? sys_rdata : bank_rd0);
        rsp_wd1_q   <= (words == 2'd2) ? bank_rd1 : '0;
      end
    end
  end

  assign cmd_ready_o = ready_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_words_o = rsp_words_q;
  assign rsp_wd0_o   = rsp_wd0_q;
  assign rsp_wd1_o   = rsp_wd1_q;

  assert_rsp_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> rsp_valid_o);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_ready_o) |=> !rsp_valid_o);

  assert_write_no_words_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && !cmd_op_i[OP_W-1]) |=> (rsp_words_o == 2'd0));

  assert_id_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_op_i == OP_RD_SYS && cmd_idx_i[SEL_W-1:0] == SYS_ID)
      |=> (rsp_wd0_o == DATA_W'(ID_VALUE)));

  assert_ready_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |=> cmd_ready_o);
endmodule

// File: tb/fpx_xfer_unit_tb_top.sv
module fpx_xfer_unit_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] ID_V = 32'h4110_2A05;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [4:0]  cmd_idx = '0;
  logic [31:0] cmd_wd0 = '0, cmd_wd1 = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_words;
  logic [31:0] rsp_wd0, rsp_wd1;

  always #2.5 clk = ~clk;

  fpx_xfer_unit #(.ID_VALUE(ID_V)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_idx_i(cmd_idx),
    .cmd_wd0_i(cmd_wd0), .cmd_wd1_i(cmd_wd1),
    .rsp_valid_o(rsp_valid), .rsp_words_o(rsp_words),
    .rsp_wd0_o(rsp_wd0), .rsp_wd1_o(rsp_wd1)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_s[32];
  logic [31:0] m_sys[8];
  logic [1:0]  nxt_words;
  logic [31:0] nxt_e0, nxt_e1;
  string       nxt_tag;
  logic        exp_v = 0;
  logic [1:0]  exp_words = 0;
  logic [31:0] exp_e0 = 0, exp_e1 = 0;
  string       exp_tag = "R1";
  bit          cmp_on = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) exp_v <= 1'b0;
    else begin
      exp_v <= cmd_valid;
      if (cmd_valid) begin
        exp_words <= nxt_words; exp_e0 <= nxt_e0; exp_e1 <= nxt_e1; exp_tag <= nxt_tag;
      end
    end
  end

  // compare every clock
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(rsp_valid == exp_v, {exp_tag, " valid"}, 64'(rsp_valid), 64'(exp_v));
      if (exp_v) begin
        chk(rsp_words == exp_words, {exp_tag, " words"}, 64'(rsp_words), 64'(exp_words));
        chk(rsp_wd0 == exp_e0, {exp_tag, " wd0"}, 64'(rsp_wd0), 64'(exp_e0));
        chk(rsp_wd1 == exp_e1, {exp_tag, " wd1"}, 64'(rsp_wd1), 64'(exp_e1));
      end
    end
  end

  task automatic issue(input logic [3:0] op, input logic [4:0] idx,
                       input logic [31:0] w0, input logic [31:0] w1, input string tag);
    logic [4:0] lo, hi, nx;
    @(negedge clk);
    lo = {idx[3:0], 1'b0}; hi = {idx[3:0], 1'b1}; nx = idx + 5'd1;
    nxt_words = 0; nxt_e0 = 0; nxt_e1 = 0; nxt_tag = tag;
    case (op)
      4'd0:  m_s[idx] = w0;
      4'd1:  m_s[lo] = w0;
      4'd2:  m_s[hi] = w0;
      4'd3:  if (idx[2:0] >= 3'd1 && idx[2:0] <= 3'd4) m_sys[idx[2:0]] = w0;
      4'd4:  begin m_s[lo] = w0; m_s[hi] = w1; end
      4'd5:  begin m_s[idx] = w0; m_s[nx] = w1; end
      4'd8:  begin nxt_words = 1; nxt_e0 = m_s[idx]; end
      4'd9:  begin nxt_words = 1; nxt_e0 = m_s[lo]; end
      4'd10: begin nxt_words = 1; nxt_e0 = m_s[hi]; end
      4'd11: begin nxt_words = 1; nxt_e0 = m_sys[idx[2:0]]; end
      4'd12: begin nxt_words = 2; nxt_e0 = m_s[lo]; nxt_e1 = m_s[hi]; end
      4'd13: begin nxt_words = 2; nxt_e0 = m_s[idx]; nxt_e1 = m_s[nx]; end
      default: ;
    endcase
    cmd_op = op; cmd_idx = idx; cmd_wd0 = w0; cmd_wd1 = w1; cmd_valid = 1'b1;
    @(posedge clk);
    #0.5 cmd_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_s[i] = '0;
    for (int i = 0; i < 8; i++) m_sys[i] = '0;
    m_sys[0] = ID_V;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b0, "R9 ready in reset", 64'(cmd_ready), 64'd0);
    chk(rsp_valid == 1'b0, "R9 rsp in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 ready after reset", 64'(cmd_ready), 64'd1);
    cmp_on = 1;

    // reset contents
    for (int i = 0; i < 32; i++) issue(4'd8, 5'(i), 0, 0, "R9 bank reset");
    for (int i = 0; i < 8; i++) issue(4'd11, 5'(i), 0, 0, "R9 sys reset");

    // alias
    issue(4'd0, 5'd5, 32'hA5A5_0005, 0, "R2 single write");
    issue(4'd10, 5'd2, 0, 0, "R2 odd single is high half");
    issue(4'd0, 5'd8, 32'h0000_0808, 0, "R2 single write");
    issue(4'd9, 5'd4, 0, 0, "R2 even single is low half");
    issue(4'd12, 5'd2, 0, 0, "R2 double view");

    // half writes
    issue(4'd4, 5'd3, 32'h1111_1111, 32'h2222_2222, "R4 dbl write");
    issue(4'd1, 5'd3, 32'h3333_3333, 0, "R3 low half write");
    issue(4'd10, 5'd3, 0, 0, "R3 high kept");
    issue(4'd2, 5'd3, 32'h4444_4444, 0, "R3 high half write");
    issue(4'd9, 5'd3, 0, 0, "R3 low kept");
    issue(4'd12, 5'd3, 0, 0, "R3 both halves");

    // double order
    issue(4'd4, 5'd7, 32'hDEAD_0001, 32'hBEEF_0002, "R4 dbl write");
    issue(4'd8, 5'd14, 0, 0, "R4 first word low");
    issue(4'd8, 5'd15, 0, 0, "R4 second word high");
    issue(4'd12, 5'd7, 0, 0, "R4 dbl read order");

    // pairs
    issue(4'd5, 5'd31, 32'hCAFE_001F, 32'hCAFE_0000, "R5 pair wrap write");
    issue(4'd8, 5'd31, 0, 0, "R5 S31");
    issue(4'd8, 5'd0, 0, 0, "R5 wrap to S0");
    issue(4'd13, 5'd31, 0, 0, "R5 pair wrap read");
    issue(4'd5, 5'd9, 32'h0909_0909, 32'h0A0A_0A0A, "R5 odd pair");
    issue(4'd12, 5'd5, 0, 0, "R5 odd pair splits doubles");
    issue(4'd10, 5'd4, 0, 0, "R5 odd pair low part");
    issue(4'd5, 5'd6, 32'h0606_0606, 32'h0707_0707, "R5 even pair");
    issue(4'd13, 5'd6, 0, 0, "R5 pair read");

    // system registers
    for (int s = 1; s <= 4; s++) issue(4'd3, 5'(s), 32'h5000_0000 + 32'(s), 0, "R6 sys write");
    for (int s = 1; s <= 4; s++) issue(4'd11, 5'(s), 0, 0, "R6 sys readback");
    issue(4'd3, 5'd0, 32'hFFFF_FFFF, 0, "R7 id write completes");
    issue(4'd11, 5'd0, 0, 0, "R7 id unchanged");
    for (int s = 5; s <= 7; s++) issue(4'd3, 5'(s), 32'h7777_0000, 0, "R8 unmapped write");
    for (int s = 1; s <= 7; s++) issue(4'd11, 5'(s), 0, 0, "R8 unmapped read zero");

    // index bit 4 ignored for doubles
    issue(4'd1, 5'h13, 32'h1313_0000, 0, "R10 dlo high idx bit");
    issue(4'd9, 5'd3, 0, 0, "R10 reaches D3");
    issue(4'd12, 5'h13, 0, 0, "R10 dbl read high idx bit");

    // unused codes
    issue(4'd6, 5'd3, 32'hFFFF_0000, 32'hFFFF_0001, "R1 unused code");
    issue(4'd7, 5'd5, 32'hFFFF_0002, 32'hFFFF_0003, "R1 unused code");
    issue(4'd14, 5'd3, 0, 0, "R1 unused code");
    issue(4'd15, 5'd3, 0, 0, "R1 unused code");
    issue(4'd12, 5'd3, 0, 0, "R1 unused left D3");
    repeat (3) @(negedge clk);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      issue(op, 5'($urandom), $urandom, $urandom, "R1 R2 R5 random");
      if ($urandom_range(0, 7) == 0) @(negedge clk);
    end
    for (int i = 0; i < 32; i++) issue(4'd8, 5'(i), 0, 0, "R2 final sweep");
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule